// File: doc/BRIEF.md
# Micro-Address Sequencer with Opcode Dispatch

This block produces the address that a microcoded controller uses each cycle to read its control store. It holds a micro-program counter and, at every clock edge, loads it with one of four sources. These are the fetch entry at address zero, a target looked up from the instruction opcode, the current address plus one, or the current address plus a signed displacement. The control word read at the current address supplies the sequencing code, the condition selector and the displacement for the next step.

The displacement path is the micro-branch. The selector picks a status line: arithmetic overflow, a pending interrupt, or either of them. When the picked line is high, the branch is taken and overrides the sequencing code. This lets an execute step divert to an exception routine without spending an extra cycle. An opcode that the lookup table does not know is sent to a fixed undefined-instruction routine. The control-store contents and the datapath lie outside this block.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `upc` becomes 0 after that edge, whatever the other inputs are.
- R2: With no branch taken, sequencing code 2'b00 loads `upc` with 0.
- R3: With no branch taken, sequencing code 2'b01 loads `upc` from the dispatch table: opcode 6'b000000 gives 4, 6'b000100 gives 3, 6'b001101 gives 6, 6'b100011 gives 8, and 6'b101011 gives 11.
- R4: With no branch taken, sequencing code 2'b01 and any opcode not listed in R3 loads `upc` with 12, the undefined-instruction routine.
- R5: With no branch taken, sequencing code 2'b10 loads `upc` with `upc`+1 modulo 16, so 15 wraps to 0.
- R6: Sequencing code 2'b11 behaves exactly as 2'b10.
- R7: The condition selector encodes 2'b00 as never, 2'b01 as the overflow flag, 2'b10 as the pending-interrupt flag, and 2'b11 as either flag. The branch is taken when the encoded condition is true.
- R8: A taken branch loads `upc` with `upc` plus `br_ofs` read as a 4-bit two's-complement value, modulo 16, whatever the sequencing code is.
- R9: A flag that the selector does not pick has no effect on `upc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Instruction opcode used by dispatch |
| seq_ctl | input | 2 | Sequencing code from the current control word |
| cond_sel | input | 2 | Micro-branch condition selector |
| br_ofs | input | 4 | Signed micro-branch displacement |
| ovf_flag | input | 1 | Arithmetic overflow status |
| irq_pend | input | 1 | Pending interrupt status |
| upc | output | 4 | Current micro-address into the control store |

## Verification
A taken micro-branch and the sequencing code always arrive in the same cycle, so the key collision is a true condition together with a dispatch, fetch or increment code. The bench sweeps every start address against every displacement while the sequencing code rotates through all four values. It then crosses all selector values with both flags under each code, and judges each next address against an arithmetic model that puts the branch first. Reset is also applied while an increment is requested, and the bench checks that reset wins.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    SEQ_FETCH    = 2'b00,
    SEQ_DISPATCH = 2'b01,
    SEQ_STEP     = 2'b10,
    SEQ_STEP_ALT = 2'b11
  } seq_code_e;

  typedef enum logic [1:0] {
    CSEL_NEVER = 2'b00,
    CSEL_OVF   = 2'b01,
    CSEL_IRQ   = 2'b10,
    CSEL_ANY   = 2'b11
  } cond_sel_e;

  localparam int TBL_ENTRIES = 5;
  localparam int TBL_KEY_W   = 6;
  localparam int TBL_VAL_W   = 4;

  // entry i occupies [i*W +: W]
  localparam logic [TBL_ENTRIES*TBL_KEY_W-1:0] TBL_KEYS =
    {6'b101011, 6'b100011, 6'b001101, 6'b000100, 6'b000000};
  localparam logic [TBL_ENTRIES*TBL_VAL_W-1:0] TBL_VALS =
    {4'd11, 4'd8, 4'd6, 4'd3, 4'd4};

  function automatic logic cond_pick(input logic [1:0] sel,
                                     input logic ovf,
                                     input logic irq);
    case (sel)
      CSEL_OVF: return ovf;
      CSEL_IRQ: return irq;
      CSEL_ANY: return ovf | irq;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/useq_dispatch_rom.sv
module useq_dispatch_rom #(
  parameter int OPC_W      = 6,
  parameter int UA_W       = 4,
  parameter int UNDEF_ADDR = 12
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [UA_W-1:0]  target,
  output logic             hit
);
  import useq_pkg::*;

  logic [TBL_ENTRIES-1:0] match;
  logic [UA_W-1:0]        entry_val [TBL_ENTRIES];

  for (genvar i = 0; i < TBL_ENTRIES; i++) begin : g_entry
    assign match[i]     = (opcode == OPC_W'(TBL_KEYS[i*TBL_KEY_W +: TBL_KEY_W]));
    assign entry_val[i] = UA_W'(TBL_VALS[i*TBL_VAL_W +: TBL_VAL_W]);
  end

  always_comb begin
    target = UA_W'(UNDEF_ADDR);
    for (int i = 0; i < TBL_ENTRIES; i++) begin
      if (match[i]) target = entry_val[i];
    end
  end

  assign hit = |match;

endmodule

// File: rtl/useq_cond_mux.sv
module useq_cond_mux (
  input  logic [1:0] cond_sel,
  input  logic       ovf_flag,
  input  logic       irq_pend,
  output logic       take
);
  import useq_pkg::*;

  assign take = cond_pick(cond_sel, ovf_flag, irq_pend);

endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel #(
  parameter int UA_W  = 4,
  parameter int OFS_W = 4
) (
  input  logic [UA_W-1:0]  cur,
  input  logic [1:0]       seq_ctl,
  input  logic [UA_W-1:0]  disp_target,
  input  logic             take,
  input  logic [OFS_W-1:0] ofs,
  output logic [UA_W-1:0]  nxt
);
  import useq_pkg::*;

  localparam int EXT_W = UA_W + OFS_W;

  function automatic logic [UA_W-1:0] add_disp(input logic [UA_W-1:0]  base,
                                               input logic [OFS_W-1:0] d);
    logic [EXT_W-1:0] wide;
    wide = {{UA_W{d[OFS_W-1]}}, d};
    return base + wide[UA_W-1:0];
  endfunction

  function automatic logic [UA_W-1:0] incr(input logic [UA_W-1:0] base);
    return base + UA_W'(1);
  endfunction

  logic [UA_W-1:0] seq_nxt;

  always_comb begin
    case (seq_ctl)
      SEQ_FETCH:    seq_nxt = '0;
      SEQ_DISPATCH: seq_nxt = disp_target;
      default:      seq_nxt = incr(cur);
    endcase
  end

  assign nxt = take ? add_disp(cur, ofs) : seq_nxt;

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer #(
  parameter int OPC_W      = 6,
  parameter int UA_W       = 4,
  parameter int OFS_W      = 4,
  parameter int UNDEF_ADDR = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic [1:0]       seq_ctl,
  input  logic [1:0]       cond_sel,
  input  logic [OFS_W-1:0] br_ofs,
  input  logic             ovf_flag,
  input  logic             irq_pend,
  output logic [UA_W-1:0]  upc
);

  logic [UA_W-1:0] upc_q;
  logic [UA_W-1:0] upc_d;
  logic [UA_W-1:0] disp_target;
  logic            disp_hit;
  logic            br_take;

  useq_dispatch_rom #(
    .OPC_W(OPC_W), .UA_W(UA_W), .UNDEF_ADDR(UNDEF_ADDR)
  ) rom_i (
    .opcode(opcode), .target(disp_target), .hit(disp_hit)
  );

  useq_cond_mux cmux_i (
    .cond_sel(cond_sel), .ovf_flag(ovf_flag), .irq_pend(irq_pend), .take(br_take)
  );

  useq_next_sel #(
    .UA_W(UA_W), .OFS_W(OFS_W)
  ) nsel_i (
    .cur(upc_q), .seq_ctl(seq_ctl), .disp_target(disp_target),
    .take(br_take), .ofs(br_ofs), .nxt(upc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) upc_q <= '0;
    else     upc_q <= upc_d;
  end

  assign upc = upc_q;

endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int OPC_W      = 6,
  parameter int UA_W       = 4,
  parameter int OFS_W      = 4,
  parameter int UNDEF_ADDR = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [OPC_W-1:0] opcode,
  input logic [1:0]       seq_ctl,
  input logic [1:0]       cond_sel,
  input logic [OFS_W-1:0] br_ofs,
  input logic             ovf_flag,
  input logic             irq_pend,
  input logic [UA_W-1:0]  upc,
  input logic             br_take,
  input logic             disp_hit
);

  logic [UA_W+OFS_W-1:0] ofs_wide;
  assign ofs_wide = {{UA_W{br_ofs[OFS_W-1]}}, br_ofs};

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (upc == '0));

  assert_fetch_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (!br_take && seq_ctl == 2'b00) |=> (upc == '0));

  assert_dispatch_lw_R3: assert property (@(posedge clk) disable iff (rst)
    (!br_take && seq_ctl == 2'b01 && opcode == OPC_W'(6'b100011)) |=> (upc == UA_W'(8)));

  assert_undef_route_R4: assert property (@(posedge clk) disable iff (rst)
    (!br_take && seq_ctl == 2'b01 && !disp_hit) |=> (upc == UA_W'(UNDEF_ADDR)));

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!br_take && seq_ctl[1]) |=> (upc == UA_W'($past(upc) + UA_W'(1))));

  assert_never_sel_R7: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 2'b00) |-> !br_take);

  assert_branch_target_R8: assert property (@(posedge clk) disable iff (rst)
    br_take |=> (upc == UA_W'($past(upc) + $past(ofs_wide[UA_W-1:0]))));

  assert_unpicked_flag_R9: assert property (@(posedge clk) disable iff (rst)
    ((cond_sel == 2'b01 && !ovf_flag) || (cond_sel == 2'b10 && !irq_pend)) |-> !br_take);

endmodule

bind useq_sequencer useq_sequencer_chk #(
  .OPC_W(OPC_W), .UA_W(UA_W), .OFS_W(OFS_W), .UNDEF_ADDR(UNDEF_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .opcode(opcode), .seq_ctl(seq_ctl), .cond_sel(cond_sel),
  .br_ofs(br_ofs), .ovf_flag(ovf_flag), .irq_pend(irq_pend), .upc(upc),
  .br_take(br_take), .disp_hit(disp_hit)
);

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] opcode;
  logic [1:0] seq_ctl;
  logic [1:0] cond_sel;
  logic [3:0] br_ofs;
  logic       ovf_flag;
  logic       irq_pend;
  logic [3:0] upc;

  int checks = 0;
  int errors = 0;
  int mdl    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_sequencer dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .seq_ctl(seq_ctl), .cond_sel(cond_sel),
    .br_ofs(br_ofs), .ovf_flag(ovf_flag), .irq_pend(irq_pend), .upc(upc)
  );

  function automatic int table_of(input int opc);
    case (opc)
      0:  return 4;
      4:  return 3;
      13: return 6;
      35: return 8;
      43: return 11;
      default: return -1;
    endcase
  endfunction

  function automatic bit cond_true(input int sel, input bit ovf, input bit irq);
    if (sel == 1) return ovf;
    if (sel == 2) return irq;
    if (sel == 3) return ovf || irq;
    return 0;
  endfunction

  function automatic int model_next(input int cur, input int seq, input int sel,
                                    input int ofs, input bit ovf, input bit irq,
                                    input int opc);
    int d;
    if (cond_true(sel, ovf, irq)) begin
      d = (ofs >= 8) ? ofs - 16 : ofs;
      return ((cur + d) % 16 + 16) % 16;
    end
    if (seq == 0) return 0;
    if (seq == 1) return (table_of(opc) < 0) ? 12 : table_of(opc);
    return (cur + 1) % 16;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s upc actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit r, input int seq, input int sel,
                      input int ofs, input bit ovf, input bit irq, input int opc);
    int exp;
    @(negedge clk);
    rst = r; seq_ctl = 2'(seq); cond_sel = 2'(sel); br_ofs = 4'(ofs);
    ovf_flag = ovf; irq_pend = irq; opcode = 6'(opc);
    exp = r ? 0 : model_next(mdl, seq, sel, ofs, ovf, irq, opc);
    @(posedge clk); #1;
    check(tag, int'(upc), exp);
    mdl = exp;
  endtask

  task automatic goto_addr(input int a);
    step("R2", 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < a; k++) step("R5", 0, 2, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; seq_ctl = 2; cond_sel = 0; br_ofs = 0; ovf_flag = 0; irq_pend = 0; opcode = 0;
    // R1: reset state
    step("R1", 1, 2, 3, 7, 1, 1, 0);
    step("R1", 1, 1, 0, 0, 0, 0, 63);
    // R5: increment with wrap
    for (int k = 0; k < 18; k++) step("R5", 0, 2, 0, 0, 0, 0, 0);
    // R6: reserved code steps
    for (int k = 0; k < 17; k++) step("R6", 0, 3, 0, 0, 0, 0, 0);
    // R1: reset beats an increment request mid-run
    goto_addr(5);
    step("R1", 1, 2, 0, 0, 0, 0, 0);
    // R2: fetch from every address
    for (int a = 0; a < 16; a++) begin
      goto_addr(a);
      step("R2", 0, 0, 0, 0, 0, 0, 0);
    end
    // R3 / R4: every opcode dispatched
    for (int o = 0; o < 64; o++) begin
      step((table_of(o) < 0) ? "R4" : "R3", 0, 1, 0, 0, 0, 0, o);
    end
    // R8: every start address and displacement, branch over each code
    for (int a = 0; a < 16; a++) begin
      for (int o = 0; o < 16; o++) begin
        goto_addr(a);
        step("R8", 0, (a + o) % 4, 1, o, 1, 0, 6'b100011);
      end
    end
    // R7 / R9: selector crossed with flags and codes
    for (int sel = 0; sel < 4; sel++) begin
      for (int f = 0; f < 4; f++) begin
        for (int s = 0; s < 4; s++) begin
          bit ov, iq;
          ov = f[0]; iq = f[1];
          goto_addr(3);
          step((!cond_true(sel, ov, iq) && (ov || iq)) ? "R9" : "R7",
               0, s, sel, 5, ov, iq, 6'b111111);
        end
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule